// File: doc/BRIEF.md
# Counter Test Pattern Source

This block is a debug data source placed in front of a frame capture stage. It produces beats of four complex samples, each with a 16-bit real and a 16-bit imaginary part, in the same lane layout as the live datapath. When the mode input selects the pattern, each sample's real part is its position within a 512-sample frame. Each sample's imaginary part is a frame number that steps by one whenever the position wraps. A single capture therefore shows any dropped, repeated, reordered or misaligned sample directly in its values.

When the mode input selects live data, the four-lane live stream is passed through instead. Both sources go through the same output register, so both paths have one cycle of latency. Both streams use valid/ready handshakes. A beat moves on a port when valid and ready are both high at a rising clock edge. An output beat that has been offered stays unchanged until it is taken. The live input is ready only when live mode is selected and the output register can accept a beat, which is when the register is empty or its beat is being taken.

A synchronous clear input brings the pattern back to position 0 of frame 0 without touching the output register.

Top module: `ctp_pattern_source`

## Requirements
- R1: Lane l (0..3) of a 128-bit beat occupies bits [32l+31:32l], with its real part in bits [32l+15:32l] and its imaginary part in bits [32l+31:32l+16]. On a pattern beat the four lanes carry real values 4k, 4k+1, 4k+2, 4k+3 and equal imaginary values.
- R2: Pattern real values run from 0 to 511 within a frame, so a frame lasts 128 beats. The beat after the one that ends with 511 starts again at 0, and its frame number is one higher.
- R3: The frame number is 16 bits wide and wraps from 65535 to 0.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the next cycle.
- R5: Pattern position and frame number advance only when a pattern beat is loaded into the output register. Stalls never cause a gap or a repeat in the sequence of beats taken.
- R6: In live mode (pat_sel = 0), in_ready equals (!out_valid || out_ready). A live beat accepted at an edge appears unchanged on out_data one cycle later, with out_valid high.
- R7: In pattern mode (pat_sel = 1), in_ready is low, and in_valid and in_data have no effect on the output.
- R8: pat_clr high at an edge sets the pattern state to position 0, frame 0. A pattern beat loaded at that same edge still carries the values from before the clear, and the next pattern beat carries real values 0..3 and frame 0.
- R9: After reset, out_valid is low, and the first pattern beat carries real values 0..3 with frame 0.
- R10: The mode is sampled on each load. The pattern state is held while live mode is selected and resumes from where it stopped when pattern mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_clr | input | 1 | Synchronous clear of pattern position and frame number |
| pat_sel | input | 1 | 1 selects the counter pattern, 0 selects the live input |
| in_valid | input | 1 | Live beat valid |
| in_ready | output | 1 | Live beat accepted |
| in_data | input | 128 | Live beat, four lanes of 16-bit real and 16-bit imaginary |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the output beat |
| out_data | output | 128 | Output beat, same lane layout |

## Verification
The bench stalls the output at random while pattern mode runs. A design that advanced its counters on offered beats rather than on loads would show gaps, and one that reloaded under a stall would change out_data before the beat is taken. Runs are long enough to cross frame ends, and a reduced-frame instance runs through the full 16-bit frame-number wrap. This catches off-by-one wraps, a frame number that steps at the wrong beat, and a wrap that saturates. Clear pulses and mode switches land on stalled and on loading cycles. These expose a clear that also corrupts the beat being loaded, pattern state that drifts while live data flows, and live data leaking into pattern beats.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

  typedef enum logic {
    SRC_LIVE    = 1'b0,
    SRC_PATTERN = 1'b1
  } src_e;

  function automatic int pos_width(input int beats);
    return (beats > 1) ? $clog2(beats) : 1;
  endfunction

endpackage

// File: rtl/ctp_counter.sv
module ctp_counter #(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 512,
  parameter int SAMPLE_W  = 16,
  localparam int BEATS    = FRAME_LEN / LANES,
  localparam int POS_W    = ctp_pkg::pos_width(BEATS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                adv,
  output logic [POS_W-1:0]    pos,
  output logic [SAMPLE_W-1:0] frame
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BEATS - 1);

  logic at_last;
  assign at_last = (pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      frame <= '0;
    end else if (clr) begin
      pos   <= '0;
      frame <= '0;
    end else if (adv) begin
      if (at_last) begin
        pos   <= '0;
        frame <= frame + SAMPLE_W'(1);
      end else begin
        pos   <= pos + POS_W'(1);
      end
    end
  end

  // R5: state held when no pattern beat is loaded
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> ($stable(pos) && $stable(frame)));

  // R8: clear lands on position 0, frame 0
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pos == '0 && frame == '0));

  // R2, R3: frame number steps (modulo width) exactly on the position wrap
  a_r2_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && at_last) |=> (pos == '0 && frame == $past(frame) + SAMPLE_W'(1)));

  // R5: mid-frame advance keeps the frame number
  a_r5_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !at_last) |=> ($stable(frame) && pos != '0));

endmodule

// File: rtl/ctp_lane_pack.sv
module ctp_lane_pack #(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 512,
  parameter int SAMPLE_W  = 16,
  localparam int BEATS    = FRAME_LEN / LANES,
  localparam int POS_W    = ctp_pkg::pos_width(BEATS),
  localparam int LANE_W   = 2 * SAMPLE_W,
  localparam int DATA_W   = LANES * LANE_W
) (
  input  logic [POS_W-1:0]    pos,
  input  logic [SAMPLE_W-1:0] frame,
  output logic [DATA_W-1:0]   beat
);

  logic [SAMPLE_W-1:0] base;
  assign base = SAMPLE_W'(pos) * SAMPLE_W'(LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign beat[l*LANE_W +: SAMPLE_W]            = base + SAMPLE_W'(l);
    assign beat[l*LANE_W + SAMPLE_W +: SAMPLE_W] = frame;
  end

endmodule

// File: rtl/ctp_out_stage.sv
module ctp_out_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctp_pkg::src_e     src,
  input  logic [DATA_W-1:0] pat_data,
  output logic              pat_take,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic can_load;
  assign can_load = !out_valid || out_ready;
  assign in_ready = (src == ctp_pkg::SRC_LIVE) && can_load;
  assign pat_take = (src == ctp_pkg::SRC_PATTERN) && can_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (can_load) begin
      if (src == ctp_pkg::SRC_PATTERN) begin
        out_valid <= 1'b1;
        out_data  <= pat_data;
      end else begin
        out_valid <= in_valid;
        out_data  <= in_data;
      end
    end
  end

  // R4: offered beat held under back-pressure
  a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: live input never accepted in pattern mode
  a_r7_no_live_take: assert property (@(posedge clk) disable iff (!rst_n)
    (src == ctp_pkg::SRC_PATTERN) |-> !in_ready);

  // R6: accepted live beat shows up on the next cycle
  a_r6_live_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  // R5: a pattern load always leaves a valid beat behind
  a_r5_pattern_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pat_take |=> out_valid);

endmodule

// File: rtl/ctp_pattern_source.sv
module ctp_pattern_source #(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 512,
  parameter int SAMPLE_W  = 16,
  localparam int BEATS    = FRAME_LEN / LANES,
  localparam int POS_W    = ctp_pkg::pos_width(BEATS),
  localparam int DATA_W   = LANES * 2 * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pat_clr,
  input  logic              pat_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic [POS_W-1:0]    pos;
  logic [SAMPLE_W-1:0] frame;
  logic [DATA_W-1:0]   pat_data;
  logic                pat_take;
  ctp_pkg::src_e       src;

  assign src = ctp_pkg::src_e'(pat_sel);

  ctp_counter #(
    .LANES(LANES), .FRAME_LEN(FRAME_LEN), .SAMPLE_W(SAMPLE_W)
  ) i_counter (
    .clk(clk), .rst_n(rst_n), .clr(pat_clr), .adv(pat_take),
    .pos(pos), .frame(frame)
  );

  ctp_lane_pack #(
    .LANES(LANES), .FRAME_LEN(FRAME_LEN), .SAMPLE_W(SAMPLE_W)
  ) i_pack (
    .pos(pos), .frame(frame), .beat(pat_data)
  );

  ctp_out_stage #(
    .DATA_W(DATA_W)
  ) i_out (
    .clk(clk), .rst_n(rst_n), .src(src), .pat_data(pat_data),
    .pat_take(pat_take), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // R1: lanes of an offered pattern beat share one frame number
  a_r1_lane_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pat_take |=> (out_data[SAMPLE_W +: SAMPLE_W] ==
                  out_data[DATA_W-SAMPLE_W +: SAMPLE_W]));

endmodule

// File: tb/test_ctp_pattern_source.sv
`timescale 1ns/100ps
module test_ctp_pattern_source;

  localparam int LANES = 4;
  localparam int BPF   = 128;
  localparam int DW    = 128;
  localparam int WRAP_BEATS = 131074;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          clr = 1'b0, sel = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid;
  logic [DW-1:0] out_data;

  logic          w_in_ready, w_valid;
  logic [DW-1:0] w_data;

  ctp_pattern_source i_ctp_pattern_source (
    .clk(clk), .rst_n(rst_n), .pat_clr(clr), .pat_sel(sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  ctp_pattern_source #(.FRAME_LEN(8)) i_ctp_pattern_source_wrap (
    .clk(clk), .rst_n(rst_n), .pat_clr(1'b0), .pat_sel(1'b1),
    .in_valid(1'b0), .in_ready(w_in_ready), .in_data('0),
    .out_valid(w_valid), .out_ready(1'b1), .out_data(w_data)
  );

  int total = 0, bad = 0;
  bit finished = 0, wrap_done = 0;

  logic          m_valid = 1'b0;
  logic [DW-1:0] m_data = '0;
  int            m_pos = 0, m_frame = 0;

  function automatic logic [DW-1:0] pat(input int pos, input int frame);
    logic [DW-1:0] d;
    d = '0;
    for (int l = 0; l < LANES; l++) begin
      d[l*32 +: 16]      = 16'(pos * LANES + l);
      d[l*32 + 16 +: 16] = 16'(frame);
    end
    return d;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives inputs for the next edge, checks, advances model.
  task automatic step(input string tag, input logic c, input logic s, input logic iv,
                      input logic [DW-1:0] id, input logic rdy);
    logic can;
    clr = c; sel = s; in_valid = iv; in_data = id; out_ready = rdy;
    #1;
    can = !m_valid || rdy;
    chk(s ? "R7 in_ready" : "R6 in_ready", DW'(in_ready), DW'(!s && can));
    @(posedge clk);
    if (can) begin
      if (s) begin
        m_valid = 1'b1;
        m_data  = pat(m_pos, m_frame);
        m_pos++;
        if (m_pos == BPF) begin
          m_pos = 0;
          m_frame = (m_frame + 1) % 65536;
        end
      end else begin
        m_valid = iv;
        m_data  = id;
      end
    end
    if (c) begin
      m_pos = 0;
      m_frame = 0;
    end
    @(negedge clk);
    chk({tag, " valid"}, DW'(out_valid), DW'(m_valid));
    if (m_valid) chk({tag, " data"}, out_data, m_data);
  endtask

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // R3: reduced-frame instance runs the frame number through its wrap
  initial begin
    int k;
    k = 0;
    wait (rst_n);
    while (k < WRAP_BEATS) begin
      @(negedge clk);
      if (w_valid) begin
        if (k < 3 || k >= WRAP_BEATS - 5)
          chk("R3 wrap", w_data, pat(k % 2, (k / 2) % 65536));
        k++;
      end
    end
    wrap_done = 1;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R9 reset valid", DW'(out_valid), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R9, R1: first pattern beat from reset
    step("R9 first beat", 0, 1, 0, '0, 1);
    chk("R1 first lanes", out_data, {16'd0, 16'd3, 16'd0, 16'd2, 16'd0, 16'd1, 16'd0, 16'd0});

    // R2: full-rate run across two frame ends
    for (int i = 0; i < 300; i++) step("R2 full rate", 0, 1, 0, '0, 1);

    // R4, R5: random stalls
    for (int i = 0; i < 300; i++) step("R4 stall", 0, 1, 0, '0, ($urandom % 2) == 0);

    // R8: clear on a loading cycle, then on a stalled cycle
    step("R8 pre", 0, 1, 0, '0, 1);
    step("R8 clear load", 1, 1, 0, '0, 1);
    step("R8 after clear", 0, 1, 0, '0, 1);
    chk("R8 zero beat", out_data, pat(0, 0));
    for (int i = 0; i < 5; i++) step("R8 run", 0, 1, 0, '0, 1);
    step("R8 clear stall", 1, 1, 0, '0, 0);
    step("R8 resume", 0, 1, 0, '0, 1);
    chk("R8 stall zero beat", out_data, pat(0, 0));

    // R6: live passthrough with random valid and ready
    for (int i = 0; i < 200; i++)
      step("R6 live", 0, 0, ($urandom % 3) != 0, rnd128(), ($urandom % 4) != 0);

    // R7: live traffic ignored in pattern mode
    for (int i = 0; i < 100; i++)
      step("R7 ignore", 0, 1, 1, rnd128(), ($urandom % 3) != 0);

    // R10: random mode switches, rare clears
    for (int i = 0; i < 500; i++)
      step("R10 mix", ($urandom % 40) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
           rnd128(), ($urandom % 3) != 0);

    wait (wrap_done);
    summary();
  end

endmodule